// File: doc/BRIEF.md
# Delayed-Load Register File with Program-Counter Chain

This block holds the architectural integer registers of a simple in-order core. The core has a one-instruction load delay slot and a one-instruction branch delay slot. When an instruction retires, the block takes three optional inputs: an ordinary register write, a fresh load result, and a jump or branch target. It applies them in a fixed order.

A load result is never written straight into the array. It is parked in a pending index/value pair, and it reaches its register only when the following instruction retires. A separate bypass port lets partial-word merge logic see the parked value before that happens.

A chain of three registers (previous, current and next program counter) gives the branch delay slot. Each committed retire shifts the chain by one. The new next-PC is either the step value or a supplied target. A retire flagged as faulting changes nothing, and neither does a cycle with no retire.

Top module: `dlrf_top`

## Requirements
- R1: On a committed retire with the write enable set, the register at the write index reads back the write data through the read ports from the next cycle on.
- R2: A load result given on a committed retire is moved into the pending pair, which is visible on the pending index and data outputs. It reaches its register only at the next committed retire.
- R3: A committed retire without the load enable sets the pending pair to index 0, value 0.
- R4: Within one committed retire, the pending load write-back is applied after the ordinary write. When both name the same register, that register takes the load value.
- R5: Register 0 reads as zero on every read port at all times, even after a write or a load aimed at it.
- R6: The bypass port returns the pending data when its index equals the pending index. Otherwise it returns the register contents.
- R7: On a committed retire, previous-PC takes PC and PC takes next-PC.
- R8: On a committed retire, next-PC becomes the target input when the target select is high. Otherwise it becomes next-PC plus 4.
- R9: With the link enable set, the ordinary write stores next-PC plus 4, as next-PC stood before the retire, and the write data input is ignored.
- R10: A retire with the fault flag set, or a cycle with the retire strobe low, leaves all registers, the pending pair and the PC chain unchanged.
- R11: After reset all registers and the pending pair are zero, previous-PC is zero, PC equals the reset vector and next-PC equals the reset vector plus 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retire_i | input | 1 | An instruction retires this cycle |
| fault_i | input | 1 | The retiring instruction raised an exception |
| wr_en_i | input | 1 | Ordinary write enable |
| wr_idx_i | input | 5 | Ordinary write register index |
| wr_data_i | input | 32 | Ordinary write data |
| link_en_i | input | 1 | Ordinary write stores next-PC plus 4 |
| ld_en_i | input | 1 | Retiring instruction is a load |
| ld_idx_i | input | 5 | Load destination index |
| ld_data_i | input | 32 | Load result |
| tgt_sel_i | input | 1 | Use target input for next-PC |
| tgt_i | input | 32 | Branch or jump target |
| rd_a_idx_i | input | 5 | Read port A index |
| rd_a_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 5 | Read port B index |
| rd_b_o | output | 32 | Read port B data |
| byp_idx_i | input | 5 | Bypass read index |
| byp_o | output | 32 | Bypass read data |
| pend_idx_o | output | 5 | Pending load index |
| pend_data_o | output | 32 | Pending load value |
| pc_o | output | 32 | Current PC |
| npc_o | output | 32 | Next PC |
| ppc_o | output | 32 | Previous PC |

## Verification
The ordinary write, the pending pair and the PC chain all change at the first rising edge after a committed retire. A load value shows in the array only after a second committed retire. The read and bypass ports are combinational. Each scenario drives its inputs in the low clock phase and removes them just after the rising edge. Results are read only in a later low phase, so every check sees the state as it stands after the edge it depends on. Load checks read the register once after the first retire, where it must still hold the old value, and again after the second.

// File: rtl/dlrf_pkg.sv
package dlrf_pkg;
  localparam int XLEN  = 32;
  localparam int NREG  = 32;
  localparam int IDX_W = $clog2(NREG);
  localparam int STEP  = 4;
endpackage

// File: rtl/dlrf_regs.sv
module dlrf_regs #(
  parameter int XLEN  = 32,
  parameter int NREG  = 32,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [XLEN-1:0]  wr_data_i,
  input  logic [IDX_W-1:0] pend_idx_i,
  input  logic [XLEN-1:0]  pend_data_i,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  output logic [XLEN-1:0]  rd_a_o,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  output logic [XLEN-1:0]  rd_b_o,
  input  logic [IDX_W-1:0] byp_idx_i,
  output logic [XLEN-1:0]  byp_o
);
  logic [XLEN-1:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    logic [XLEN-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (commit_i) begin
        // order: ordinary write, then pending load, then r0 clamp
        if (g == 0)                                      q <= '0;
        else if (pend_idx_i == IDX_W'(g))                q <= pend_data_i;
        else if (wr_en_i && wr_idx_i == IDX_W'(g))       q <= wr_data_i;
      end
    end
    assign mem[g] = q;
  end

  assign rd_a_o = mem[rd_a_idx_i];
  assign rd_b_o = mem[rd_b_idx_i];
  assign byp_o  = (byp_idx_i == pend_idx_i) ? pend_data_i : mem[byp_idx_i];

  a_r2_load_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && pend_idx_i != '0 |=> mem[$past(pend_idx_i)] == $past(pend_data_i));
  a_r1_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && wr_en_i && wr_idx_i != '0 && wr_idx_i != pend_idx_i
    |=> mem[$past(wr_idx_i)] == $past(wr_data_i));
  a_r5_zero_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_b_idx_i == '0 |-> rd_b_o == '0);
  a_r10_array_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> mem[$past(rd_a_idx_i)] == $past(rd_a_o));
endmodule

// File: rtl/dlrf_pend.sv
module dlrf_pend #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic             ld_en_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [XLEN-1:0]  ld_data_i,
  output logic [IDX_W-1:0] pend_idx_o,
  output logic [XLEN-1:0]  pend_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_idx_o  <= '0;
      pend_data_o <= '0;
    end else if (commit_i) begin
      pend_idx_o  <= ld_en_i ? ld_idx_i  : '0;
      pend_data_o <= ld_en_i ? ld_data_i : '0;
    end
  end

  a_r3_nonload_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && !ld_en_i |=> pend_idx_o == '0 && pend_data_o == '0);
  a_r2_pend_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && ld_en_i |=> pend_idx_o == $past(ld_idx_i) && pend_data_o == $past(ld_data_i));
  a_r10_pend_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(pend_idx_o) && $stable(pend_data_o));
endmodule

// File: rtl/dlrf_pc_chain.sv
module dlrf_pc_chain #(
  parameter int              XLEN      = 32,
  parameter int              STEP      = 4,
  parameter logic [XLEN-1:0] RESET_VEC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            commit_i,
  input  logic            tgt_sel_i,
  input  logic [XLEN-1:0] tgt_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] npc_o,
  output logic [XLEN-1:0] ppc_o,
  output logic [XLEN-1:0] link_o
);
  localparam logic [XLEN-1:0] StepV = XLEN'(STEP);

  assign link_o = npc_o + StepV;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ppc_o <= '0;
      pc_o  <= RESET_VEC;
      npc_o <= RESET_VEC + StepV;
    end else if (commit_i) begin
      ppc_o <= pc_o;
      pc_o  <= npc_o;
      npc_o <= tgt_sel_i ? tgt_i : link_o;
    end
  end

  a_r7_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> pc_o == $past(npc_o) && ppc_o == $past(pc_o));
  a_r8_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && !tgt_sel_i |=> npc_o == $past(npc_o) + StepV);
  a_r8_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && tgt_sel_i |=> npc_o == $past(tgt_i));
  a_r10_pc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(pc_o) && $stable(npc_o) && $stable(ppc_o));
endmodule

// File: rtl/dlrf_top.sv
module dlrf_top
  import dlrf_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0040_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             retire_i,
  input  logic             fault_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [XLEN-1:0]  wr_data_i,
  input  logic             link_en_i,
  input  logic             ld_en_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [XLEN-1:0]  ld_data_i,
  input  logic             tgt_sel_i,
  input  logic [XLEN-1:0]  tgt_i,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  output logic [XLEN-1:0]  rd_a_o,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  output logic [XLEN-1:0]  rd_b_o,
  input  logic [IDX_W-1:0] byp_idx_i,
  output logic [XLEN-1:0]  byp_o,
  output logic [IDX_W-1:0] pend_idx_o,
  output logic [XLEN-1:0]  pend_data_o,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  npc_o,
  output logic [XLEN-1:0]  ppc_o
);
  logic            commit;
  logic [XLEN-1:0] link_addr;
  logic [XLEN-1:0] wdata;

  assign commit = retire_i & ~fault_i;
  assign wdata  = link_en_i ? link_addr : wr_data_i;

  dlrf_pend #(.XLEN(XLEN), .IDX_W(IDX_W)) u_pend (
    .clk_i, .rst_ni, .commit_i(commit),
    .ld_en_i, .ld_idx_i, .ld_data_i,
    .pend_idx_o, .pend_data_o
  );

  dlrf_regs #(.XLEN(XLEN), .NREG(NREG), .IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni, .commit_i(commit),
    .wr_en_i, .wr_idx_i, .wr_data_i(wdata),
    .pend_idx_i(pend_idx_o), .pend_data_i(pend_data_o),
    .rd_a_idx_i, .rd_a_o, .rd_b_idx_i, .rd_b_o,
    .byp_idx_i, .byp_o
  );

  dlrf_pc_chain #(.XLEN(XLEN), .STEP(STEP), .RESET_VEC(RESET_VEC)) u_pc (
    .clk_i, .rst_ni, .commit_i(commit),
    .tgt_sel_i, .tgt_i,
    .pc_o, .npc_o, .ppc_o, .link_o(link_addr)
  );

  a_r5_zero_port_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_a_idx_i == '0 |-> rd_a_o == '0);
  a_r9_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit && wr_en_i && link_en_i && wr_idx_i != '0 && wr_idx_i != pend_idx_o
    |=> u_regs.mem[$past(wr_idx_i)] == $past(npc_o) + XLEN'(STEP));
endmodule

// File: tb/tb_dlrf_top.sv
`timescale 1ns/1ps
module tb_dlrf_top;
  localparam logic [31:0] VEC = 32'h0040_0000;

  logic        clk_i = 0, rst_ni = 0;
  logic        retire_i = 0, fault_i = 0, wr_en_i = 0, link_en_i = 0, ld_en_i = 0, tgt_sel_i = 0;
  logic [4:0]  wr_idx_i = 0, ld_idx_i = 0, rd_a_idx_i = 0, rd_b_idx_i = 0, byp_idx_i = 0;
  logic [31:0] wr_data_i = 0, ld_data_i = 0, tgt_i = 0;
  logic [31:0] rd_a_o, rd_b_o, byp_o, pend_data_o, pc_o, npc_o, ppc_o;
  logic [4:0]  pend_idx_o;

  int checks = 0, fails = 0;
  logic [31:0] e_pc, e_npc, e_ppc;

  always #2 clk_i = ~clk_i;

  dlrf_top #(.RESET_VEC(VEC)) dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ret(bit flt, bit we, logic [4:0] wi, logic [31:0] wd, bit lk,
                     bit le, logic [4:0] li, logic [31:0] ld, bit ts, logic [31:0] tg,
                     bit rt = 1);
    @(negedge clk_i);
    retire_i = rt; fault_i = flt; wr_en_i = we; wr_idx_i = wi; wr_data_i = wd;
    link_en_i = lk; ld_en_i = le; ld_idx_i = li; ld_data_i = ld; tgt_sel_i = ts; tgt_i = tg;
    @(posedge clk_i);
    #1;
    retire_i = 0; fault_i = 0; wr_en_i = 0; link_en_i = 0; ld_en_i = 0; tgt_sel_i = 0;
    if (rt && !flt) begin
      e_ppc = e_pc; e_pc = e_npc; e_npc = ts ? tg : e_npc + 4;
    end
  endtask

  task automatic rd(logic [4:0] idx, output logic [31:0] v);
    @(negedge clk_i);
    rd_a_idx_i = idx; rd_b_idx_i = idx;
    #1 v = rd_a_o;
    if (rd_b_o !== v) chk("R5 port B agrees", rd_b_o, v);
  endtask

  task automatic chk_pc(string req);
    @(negedge clk_i);
    chk({req, " pc"}, pc_o, e_pc);
    chk({req, " npc"}, npc_o, e_npc);
    chk({req, " ppc"}, ppc_o, e_ppc);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    e_pc = VEC; e_npc = VEC + 4; e_ppc = 0;
    chk_pc("R11");
    chk("R11 pend idx", 32'(pend_idx_o), 0);
    chk("R11 pend data", pend_data_o, 0);
    rd(5'd7, v); chk("R11 reg7", v, 0);
  endtask

  task automatic t_write;
    logic [31:0] v;
    ret(0, 1, 5'd3, 32'h1111_2222, 0, 0, 0, 0, 0, 0);
    rd(5'd3, v); chk("R1 reg3", v, 32'h1111_2222);
    chk_pc("R7/R8 step");
  endtask

  task automatic t_load;
    logic [31:0] v;
    ret(0, 0, 0, 0, 0, 1, 5'd4, 32'h0000_00AA, 0, 0);
    rd(5'd4, v); chk("R2 reg4 not yet", v, 0);
    chk("R2 pend idx", 32'(pend_idx_o), 4);
    chk("R2 pend data", pend_data_o, 32'hAA);
    @(negedge clk_i); byp_idx_i = 5'd4; #1 chk("R6 bypass hit", byp_o, 32'hAA);
    byp_idx_i = 5'd3; #1 chk("R6 bypass miss", byp_o, 32'h1111_2222);
    ret(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    rd(5'd4, v); chk("R2 reg4 landed", v, 32'hAA);
    chk("R3 pend idx", 32'(pend_idx_o), 0);
    chk("R3 pend data", pend_data_o, 0);
  endtask

  task automatic t_order;
    logic [31:0] v;
    ret(0, 0, 0, 0, 0, 1, 5'd6, 32'h66, 0, 0);
    ret(0, 1, 5'd6, 32'h77, 0, 1, 5'd7, 32'h70, 0, 0);
    rd(5'd6, v); chk("R4 load wins", v, 32'h66);
    ret(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    rd(5'd7, v); chk("R2 reg7 landed", v, 32'h70);
  endtask

  task automatic t_zero;
    logic [31:0] v;
    ret(0, 1, 5'd0, 32'hFFFF_FFFF, 0, 1, 5'd0, 32'h5, 0, 0);
    rd(5'd0, v); chk("R5 after write", v, 0);
    ret(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    rd(5'd0, v); chk("R5 after load", v, 0);
  endtask

  task automatic t_branch;
    ret(0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0000_1000);
    chk_pc("R8 target");
    ret(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk_pc("R7 delay slot");
  endtask

  task automatic t_link;
    logic [31:0] v, exp;
    exp = e_npc + 4;
    ret(0, 1, 5'd31, 32'hDEAD_BEEF, 1, 0, 0, 0, 1, 32'h0000_2000);
    rd(5'd31, v); chk("R9 link", v, exp);
    chk_pc("R9 pc");
  endtask

  task automatic t_fault;
    logic [31:0] v;
    ret(0, 0, 0, 0, 0, 1, 5'd9, 32'h99, 0, 0);
    ret(1, 1, 5'd8, 32'h88, 0, 1, 5'd10, 32'h10, 1, 32'h3000);
    rd(5'd8, v); chk("R10 fault no write", v, 0);
    rd(5'd9, v); chk("R10 fault no land", v, 0);
    chk("R10 fault pend idx", 32'(pend_idx_o), 9);
    chk("R10 fault pend data", pend_data_o, 32'h99);
    chk_pc("R10 fault pc");
    ret(0, 1, 5'd8, 32'h88, 0, 1, 5'd10, 32'h10, 1, 32'h3000, 0);
    rd(5'd8, v); chk("R10 idle no write", v, 0);
    chk("R10 idle pend idx", 32'(pend_idx_o), 9);
    chk_pc("R10 idle pc");
    ret(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    rd(5'd9, v); chk("R2 reg9 after fault", v, 32'h99);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    t_reset();
    t_write();
    t_load();
    t_order();
    t_zero();
    t_branch();
    t_link();
    t_fault();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule